// File: doc/BRIEF.md
# Mask-Addressed Output Port

This block holds a general-purpose output register that software never writes as a whole word. Two write addresses act on it. A write at the set address turns on every register bit whose data bit is 1. A write at the clear address turns off every register bit whose data bit is 1. Data bits that are 0 leave the matching register bits as they were, so separate agents can own separate bits without a read-modify-write. The pins drive the inverse of the register: a register bit of 1 pulls its pin low.

Each pin can also be handed to an internal status signal through a per-bit select input. A second per-bit input marks the pin as open-drain. A selected push-pull pin shows the inverted status value. A selected open-drain pin never drives high. It drives low while its status is asserted and releases the line otherwise. The release is shown through a per-bit output-enable, because the pads lie outside this block.

Top module: `setResetOutPort`

## Requirements
- R1: While reset is asserted and after it is released, the register holds all zeros, so every general-purpose pin drives high (pinOut bit 1, pinOe bit 1).
- R2: A cycle with wrEn high and wrAddr equal to SET_ADDR (default 14) sets each register bit where wrData is 1. Bits where wrData is 0 keep their value.
- R3: A cycle with wrEn high and wrAddr equal to CLR_ADDR (default 15) clears each register bit where wrData is 1. Bits where wrData is 0 keep their value.
- R4: A cycle with wrEn low, or with any wrAddr other than SET_ADDR or CLR_ADDR, leaves the register unchanged.
- R5: A pin with funcSel bit 0 drives the complement of its register bit, with pinOe bit 1.
- R6: A pin with funcSel bit 1 and funcOd bit 0 drives the complement of its funcVal bit, with pinOe bit 1.
- R7: A pin with funcSel bit 1 and funcOd bit 1 has pinOut bit 0 and a pinOe bit equal to its funcVal bit. It drives low when the status is 1 and floats when the status is 0.
- R8: A register bit keeps its value, and accepts set and clear writes, while its pin is in function mode. When funcSel returns to 0 the pin again shows the complement of that bit.
- R9: A write changes the pins from the first rising clock edge on which it is sampled. Pins do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | WIDTH | Bit mask for a set or clear write |
| funcSel | input | WIDTH | Per-bit select: 1 hands the pin to funcVal |
| funcOd | input | WIDTH | Per-bit open-drain mark for function pins |
| funcVal | input | WIDTH | Internal status signals, one per pin |
| pinOut | output | WIDTH | Pin drive level |
| pinOe | output | WIDTH | Pin output-enable (0 = released) |

## Verification
The bench uses the default parameters: an 8-bit port, a 4-bit address, and set and clear addresses 14 and 15. The two write addresses differ only in bit 0. Because of that, a decode error that ignores the low address bit, swaps the two addresses, or accepts the neighbouring address 13 shows up on the pins. The full byte lets one pattern mix general-purpose, push-pull and open-drain pins in a single cycle. It also lets set and clear masks overlap bits that are already set or already clear.

// File: rtl/set_reset_out_pkg.sv
package set_reset_out_pkg;
  typedef struct packed {
    logic setStb;
    logic clrStb;
  } portStrobes_t;
endpackage

// File: rtl/setResetOutCtrl.sv
module setResetOutCtrl
  import set_reset_out_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int SET_ADDR = 14,
  parameter int CLR_ADDR = 15
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output portStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] SetA = ADDR_W'(SET_ADDR);
  localparam logic [ADDR_W-1:0] ClrA = ADDR_W'(CLR_ADDR);

  always_comb begin
    strobes.setStb = wrEn && (wrAddr == SetA);
    strobes.clrStb = wrEn && (wrAddr == ClrA);
  end
endmodule

// File: rtl/setResetOutData.sv
module setResetOutData
  import set_reset_out_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] portQ
);
  logic [WIDTH-1:0] setMask;
  logic [WIDTH-1:0] clrMask;
  logic [WIDTH-1:0] portNext;

  always_comb begin
    setMask  = strobes.setStb ? wrData : '0;
    clrMask  = strobes.clrStb ? wrData : '0;
    portNext = (portQ | setMask) & ~clrMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portQ <= '0;
    else       portQ <= portNext;
  end
endmodule

// File: rtl/setResetOutMux.sv
module setResetOutMux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] portQ,
  input  logic [WIDTH-1:0] funcSel,
  input  logic [WIDTH-1:0] funcOd,
  input  logic [WIDTH-1:0] funcVal,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      if (!funcSel[i]) begin
        pinOut[i] = ~portQ[i];
        pinOe[i]  = 1'b1;
      end else if (!funcOd[i]) begin
        pinOut[i] = ~funcVal[i];
        pinOe[i]  = 1'b1;
      end else begin
        pinOut[i] = 1'b0;
        pinOe[i]  = funcVal[i];
      end
    end
  end
endmodule

// File: rtl/setResetOutPort.sv
module setResetOutPort
  import set_reset_out_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 4,
  parameter int SET_ADDR = 14,
  parameter int CLR_ADDR = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [WIDTH-1:0]  funcSel,
  input  logic [WIDTH-1:0]  funcOd,
  input  logic [WIDTH-1:0]  funcVal,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe
);
  portStrobes_t     strobes;
  logic [WIDTH-1:0] portQ;

  setResetOutCtrl #(.ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes)
  );

  setResetOutData #(.WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .portQ(portQ)
  );

  setResetOutMux #(.WIDTH(WIDTH)) u_mux (
    .portQ(portQ), .funcSel(funcSel), .funcOd(funcOd), .funcVal(funcVal),
    .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/setResetOutChecker.sv
module setResetOutChecker #(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 4,
  parameter int SET_ADDR = 14,
  parameter int CLR_ADDR = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [WIDTH-1:0]  wrData,
  input logic [WIDTH-1:0]  funcSel,
  input logic [WIDTH-1:0]  funcOd,
  input logic [WIDTH-1:0]  funcVal,
  input logic [WIDTH-1:0]  pinOut,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  portQ
);
  localparam logic [ADDR_W-1:0] SetA = ADDR_W'(SET_ADDR);
  localparam logic [ADDR_W-1:0] ClrA = ADDR_W'(CLR_ADDR);

  // R1
  p_reset_zero_r1: assert property (@(posedge clk) !rstN |=> portQ == '0);

  // R2
  p_set_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == SetA) |=>
      ((portQ & $past(wrData)) == $past(wrData)) &&
      ((portQ & ~$past(wrData)) == ($past(portQ) & ~$past(wrData))));

  // R3
  p_clr_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ClrA) |=>
      ((portQ & $past(wrData)) == '0) &&
      ((portQ & ~$past(wrData)) == ($past(portQ) & ~$past(wrData))));

  // R4, R9
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrAddr == SetA || wrAddr == ClrA)) |=> $stable(portQ));

  // R5
  p_gp_pin_r5: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOut ^ ~portQ) & ~funcSel) == '0) && ((pinOe | funcSel) == '1));

  // R6
  p_pushpull_r6: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOut ^ ~funcVal) & funcSel & ~funcOd) == '0));

  // R7
  p_opendrain_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut & funcSel & funcOd) == '0) &&
    (((pinOe ^ funcVal) & funcSel & funcOd) == '0));
endmodule

bind setResetOutPort setResetOutChecker #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .funcSel(funcSel), .funcOd(funcOd), .funcVal(funcVal),
  .pinOut(pinOut), .pinOe(pinOe), .portQ(portQ)
);

// File: tb/setResetOutPort_bench.sv
module setResetOutPort_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] funcSel = '0;
  logic [7:0] funcOd = '0;
  logic [7:0] funcVal = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int  passCnt = 0;
  int  failCnt = 0;
  bit  done = 0;
  logic [7:0] refQ = '0;

  always #5 clk = ~clk;

  setResetOutPort u_setResetOutPort (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .funcSel(funcSel), .funcOd(funcOd), .funcVal(funcVal),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic compare(input string tag);
    logic [7:0] expOut, expOe;
    for (int i = 0; i < 8; i++) begin
      if (!funcSel[i])     begin expOut[i] = ~refQ[i];    expOe[i] = 1'b1; end
      else if (!funcOd[i]) begin expOut[i] = ~funcVal[i]; expOe[i] = 1'b1; end
      else                 begin expOut[i] = 1'b0;        expOe[i] = funcVal[i]; end
    end
    if (pinOut === expOut && pinOe === expOe) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: pinOut=%b pinOe=%b expected pinOut=%b pinOe=%b",
               tag, pinOut, pinOe, expOut, expOe);
    end
  endtask

  // Drive inputs after a falling edge, check, then advance the model at the rising edge.
  task automatic step(input string tag, input logic we, input logic [3:0] a,
                      input logic [7:0] d, input logic [7:0] fs,
                      input logic [7:0] fo, input logic [7:0] fv);
    wrEn = we; wrAddr = a; wrData = d;
    funcSel = fs; funcOd = fo; funcVal = fv;
    #1;
    compare(tag);
    @(posedge clk);
    if (we && a == 4'd14) refQ = refQ | d;
    if (we && a == 4'd15) refQ = refQ & ~d;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    step("R1 after reset", 0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R2 set 0xA5", 1, 4'd14, 8'hA5, 8'h00, 8'h00, 8'h00);
    step("R9 first cycle after set", 0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R2 set overlap 0x0F", 1, 4'd14, 8'h0F, 8'h00, 8'h00, 8'h00);
    step("R3 clear 0x81", 1, 4'd15, 8'h81, 8'h00, 8'h00, 8'h00);
    step("R3 clear zero mask", 1, 4'd15, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R2 set zero mask", 1, 4'd14, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R4 neighbour addr 13", 1, 4'd13, 8'hFF, 8'h00, 8'h00, 8'h00);
    step("R4 addr 6", 1, 4'd6, 8'hFF, 8'h00, 8'h00, 8'h00);
    step("R4 addr 7", 1, 4'd7, 8'hFF, 8'h00, 8'h00, 8'h00);
    step("R4 strobe low at set addr", 0, 4'd14, 8'hFF, 8'h00, 8'h00, 8'h00);
    step("R4 strobe low at clr addr", 0, 4'd15, 8'hFF, 8'h00, 8'h00, 8'h00);
    step("R5 general pins", 0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R6 push-pull status", 0, 4'd0, 8'h00, 8'hF0, 8'h00, 8'hA0);
    step("R6 push-pull status flip", 0, 4'd0, 8'h00, 8'hF0, 8'h00, 8'h50);
    step("R7 open-drain status", 0, 4'd0, 8'h00, 8'h0F, 8'h0F, 8'h05);
    step("R7 open-drain released", 0, 4'd0, 8'h00, 8'h0F, 8'h0F, 8'h00);
    step("R7 mixed modes", 0, 4'd0, 8'h00, 8'h3C, 8'h0C, 8'h28);
    step("R8 set while in function mode", 1, 4'd14, 8'hFF, 8'hFF, 8'hAA, 8'h33);
    step("R8 clear while in function mode", 1, 4'd15, 8'h3C, 8'hFF, 8'h55, 8'hCC);
    step("R8 return to general", 0, 4'd0, 8'h00, 8'h00, 8'h00, 8'hFF);
    step("R3 clear all", 1, 4'd15, 8'hFF, 8'h00, 8'h00, 8'h00);
    step("R9 first cycle after clear", 0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int k = 0; k < 8; k++)
      step("R2 walking set", 1, 4'd14, 8'(1 << k), 8'h00, 8'h00, 8'h00);
    for (int k = 0; k < 8; k++)
      step("R3 walking clear", 1, 4'd15, 8'(1 << k), 8'h00, 8'h00, 8'h00);
    step("R2 set 0x3C", 1, 4'd14, 8'h3C, 8'h00, 8'h00, 8'h00);
    rstN = 1'b0;
    refQ = '0;
    #1;
    compare("R1 reset mid-run");
    @(negedge clk);
    rstN = 1'b1;
    step("R1 after second reset", 0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end
endmodule